// File: doc/BRIEF.md
# Mode-Configurable Registered Bus Transceiver

This block is a bank of identical bit channels between two sides. The A side has a separate input bus and output bus. The B side is a single bidirectional open-collector bus. Each direction passes its data through its own logic element. A two-bit mode input selects that element as a plain buffer, a rising-edge flip-flop or a latch that is transparent while its enable is high. Whatever the mode, the value leaving an element reaches its output port inverted.

Each direction has its own clock pin, which also serves as the latch enable. A loopback control switches the source of the B-to-A element. With loopback low, the element takes the resolved B bus. With loopback high, it takes the A-to-B element's result before that result is inverted. The A output bus floats unless its enable is high. The B bus is pulled low only on bits whose driven value is 0, and only when both B enables are in their active state. Disabling an output does not stop its element from storing new data. An asynchronous active-low reset clears all storage.

Top module: `regxcvr`

## Requirements
- R1: Mode code 2'b00 selects the buffer, so the element result follows its input without any clock.
- R2: Mode code 2'b01 selects the flip-flop, which loads its input on each rising edge of that direction's clock pin and holds it between edges.
- R3: Mode codes 2'b10 and 2'b11 select the latch. The latch follows its input while the clock pin is high and keeps the last value after the pin falls.
- R4: The B bus carries the bitwise inverse of the A-to-B result, and a_out carries the bitwise inverse of the B-to-A result.
- R5: When loop_en is 1, the B-to-A element takes the A-to-B result before inversion. When loop_en is 0, it takes the resolved B bus. This holds in every A-to-B mode.
- R6: a_out is driven only while a_oe is 1. Otherwise it is high impedance, and a pulled-up net reads as all ones.
- R7: The block pulls B bus bits low only when b_oe is 1 and b_oe_n is 0. In the other three combinations it releases the bus, which then reads high.
- R8: Both elements keep loading and holding data while a_out is disabled and the B bus is released.
- R9: While rst_n is 0, both flip-flops and both latches are held at 0.
- R10: The B bus is a wired-AND. A bit pulled low by another device reads as 0 at the B-to-A input, even when the block has released that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of all storage |
| a_in | input | W | A-side input data |
| a_out | output | W | A-side output data, high impedance when disabled |
| b_bus | inout | W | Open-collector shared B-side bus |
| ab_clk | input | 1 | A-to-B clock (flip-flop) or enable (latch) |
| ba_clk | input | 1 | B-to-A clock (flip-flop) or enable (latch) |
| ab_mode | input | 2 | A-to-B element select: 00 buffer, 01 flip-flop, 1x latch |
| ba_mode | input | 2 | B-to-A element select: 00 buffer, 01 flip-flop, 1x latch |
| loop_en | input | 1 | Feeds the A-to-B result into the B-to-A element |
| a_oe | input | 1 | Active-high enable for a_out |
| b_oe | input | 1 | Active-high B bus enable |
| b_oe_n | input | 1 | Active-low B bus enable |

## Verification
Two events can meet in one step: a store in the A-to-B element, and a store in the B-to-A element whose input, under loopback, is that same A-to-B result. The bench raises ab_clk one nanosecond before ba_clk, so the second element loads the value the first one has just taken. While both pins are high, it compares a_out with the value that passed through both elements. After the pins fall and a_in changes, it checks that each latch or flip-flop still shows the held value. Random mode, enable and loopback mixes, together with external pull-downs on the B bus, are compared against a bench model of each element.

// File: rtl/regxcvr.sv
`timescale 1ns/1ps
module regxcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  inout  wire  [W-1:0] b_bus,
  input  logic         ab_clk,
  input  logic         ba_clk,
  input  logic [1:0]   ab_mode,
  input  logic [1:0]   ba_mode,
  input  logic         loop_en,
  input  logic         a_oe,
  input  logic         b_oe,
  input  logic         b_oe_n
);
  localparam logic [1:0] MODE_BUF = 2'b00;
  localparam logic [1:0] MODE_FF  = 2'b01;

  logic [W-1:0] ab_ff, ab_lat, ab_res;
  logic [W-1:0] ba_src, ba_ff, ba_lat, ba_res;
  logic         b_drive;

  function automatic logic [W-1:0] pick(input logic [1:0] m, input logic [W-1:0] d,
                                        input logic [W-1:0] f, input logic [W-1:0] l);
    if (m == MODE_BUF)     return d;
    else if (m == MODE_FF) return f;
    else                   return l;
  endfunction

  always_ff @(posedge ab_clk or negedge rst_n)
    if (!rst_n) ab_ff <= '0;
    else        ab_ff <= a_in;

  always_latch
    if (!rst_n)      ab_lat = '0;
    else if (ab_clk) ab_lat = a_in;

  assign ab_res = pick(ab_mode, a_in, ab_ff, ab_lat);
  assign ba_src = loop_en ? ab_res : b_bus;

  always_ff @(posedge ba_clk or negedge rst_n)
    if (!rst_n) ba_ff <= '0;
    else        ba_ff <= ba_src;

  always_latch
    if (!rst_n)      ba_lat = '0;
    else if (ba_clk) ba_lat = ba_src;

  assign ba_res  = pick(ba_mode, ba_src, ba_ff, ba_lat);
  assign a_out   = a_oe ? ~ba_res : 'z;
  assign b_drive = b_oe & ~b_oe_n;

  for (genvar i = 0; i < W; i++) begin : g_oc
    assign b_bus[i] = (b_drive & ab_res[i]) ? 1'b0 : 1'bz;
  end
endmodule

// File: rtl/regxcvr_chk.sv
`timescale 1ns/1ps
module regxcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_bus,
  input logic         ab_clk,
  input logic         ba_clk,
  input logic [1:0]   ab_mode,
  input logic [1:0]   ba_mode,
  input logic         loop_en,
  input logic         a_oe,
  input logic [W-1:0] ab_res,
  input logic [W-1:0] ba_src
);
  p_flop_ab_r2: assert property (@(posedge ab_clk) disable iff (!rst_n)
    (ab_mode == 2'b01) ##1 (ab_mode == 2'b01) |-> ab_res == $past(a_in));

  p_flop_ba_r2: assert property (@(posedge ba_clk) disable iff (!rst_n)
    (ba_mode == 2'b01) ##1 (ba_mode == 2'b01 && a_oe) |-> a_out == ~$past(ba_src));

  p_latch_open_r3: assert property (@(negedge ab_clk) disable iff (!rst_n)
    ab_mode[1] |-> ab_res == a_in);

  p_loop_path_r5: assert property (@(negedge ba_clk) disable iff (!rst_n)
    (loop_en && ba_mode[1] && a_oe) |-> a_out == ~ab_res);

  p_buf_invert_r4: assert property (@(posedge ba_clk) disable iff (!rst_n)
    (ba_mode == 2'b00 && !loop_en && a_oe) |-> a_out == ~b_bus);
endmodule

bind regxcvr regxcvr_chk #(.W(W)) u_chk (
  .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .b_bus(b_bus),
  .ab_clk(ab_clk), .ba_clk(ba_clk), .ab_mode(ab_mode), .ba_mode(ba_mode),
  .loop_en(loop_en), .a_oe(a_oe), .ab_res(ab_res), .ba_src(ba_src)
);

// File: tb/sim_regxcvr.sv
`timescale 1ns/1ps
module sim_regxcvr;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [7:0] a_in = '0, ext_low = '0;
  logic       ab_clk = 1'b0, ba_clk = 1'b0;
  logic [1:0] ab_mode = 2'b01, ba_mode = 2'b01;
  logic       loop_en = 1'b0, a_oe = 1'b1, b_oe = 1'b1, b_oe_n = 1'b0;
  wire  [7:0] a_out, b_bus;

  int compared = 0, mismatched = 0;
  logic [7:0] r_fab = '0, r_lab = '0, r_fba = '0, r_lba = '0;

  for (genvar i = 0; i < 8; i++) begin : g_pu
    assign b_bus[i] = ext_low[i] ? 1'b0 : 1'bz;
    pullup pb (b_bus[i]);
    pullup pa (a_out[i]);
  end

  regxcvr u0 (.rst_n(rst_n), .a_in(a_in), .a_out(a_out), .b_bus(b_bus),
              .ab_clk(ab_clk), .ba_clk(ba_clk), .ab_mode(ab_mode), .ba_mode(ba_mode),
              .loop_en(loop_en), .a_oe(a_oe), .b_oe(b_oe), .b_oe_n(b_oe_n));

  function automatic logic [7:0] m_pab();
    return (ab_mode == 2'b00) ? a_in : (ab_mode == 2'b01) ? r_fab : r_lab;
  endfunction
  function automatic logic [7:0] m_bus();
    return ~(((b_oe && !b_oe_n) ? m_pab() : 8'h00) | ext_low);
  endfunction
  function automatic logic [7:0] m_q();
    return loop_en ? m_pab() : m_bus();
  endfunction
  function automatic logic [7:0] m_ao();
    logic [7:0] p;
    p = (ba_mode == 2'b00) ? m_q() : (ba_mode == 2'b01) ? r_fba : r_lba;
    return a_oe ? ~p : 8'hFF;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] a, input logic [7:0] ext, input logic [1:0] om,
                      input logic [1:0] im, input logic lb, input logic oea, input logic obh,
                      input logic obl, input logic rab, input logic rba,
                      input logic [7:0] a2, input string tag);
    @(negedge clk);
    a_in = a; ext_low = ext; ab_mode = om; ba_mode = im; loop_en = lb;
    a_oe = oea; b_oe = obh; b_oe_n = obl;
    #1;
    if (rab) begin ab_clk = 1'b1; r_fab = a; r_lab = a; end
    #1;
    if (rba) begin r_fba = m_q(); r_lba = m_q(); ba_clk = 1'b1; end
    #1;
    chk(b_bus, m_bus(), {tag, " bus open"});
    chk(a_out, m_ao(), {tag, " a_out open"});
    ab_clk = 1'b0; ba_clk = 1'b0;
    #1 a_in = a2;
    #1;
    chk(b_bus, m_bus(), {tag, " bus held"});
    chk(a_out, m_ao(), {tag, " a_out held"});
  endtask

  initial begin
    int s;
    s = $urandom(32'd20240611);
    a_in = 8'hFF;
    #12;
    chk(b_bus, 8'hFF, "R9 reset bus");
    chk(a_out, 8'hFF, "R9 reset a_out");
    rst_n = 1'b1;
    step(8'hFF, 8'h00, 2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, "R9 post-reset hold");
    step(8'h3C, 8'h00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h96, "R1 R4 buffer");
    step(8'hA5, 8'h00, 2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h11, "R2 flop");
    step(8'h5A, 8'h00, 2'b10, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hE7, "R3 latch 10");
    step(8'hC3, 8'h00, 2'b11, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h0F, "R3 latch 11");
    for (int m = 0; m < 3; m++) begin
      step(8'h69 + 8'(m), 8'h00, 2'(m) << (m == 2 ? 0 : 0), 2'b10, 1'b1, 1'b1, 1'b0, 1'b0,
           1'b1, 1'b1, 8'h81, "R5 loopback");
      step(8'h17 ^ 8'(m), 8'hFF, 2'(m), 2'b01, 1'b1, 1'b1, 1'b1, 1'b0,
           1'b1, 1'b1, 8'h42, "R5 loopback ignores bus");
    end
    for (int c = 0; c < 4; c++)
      step(8'hFF, 8'h00, 2'b00, 2'b00, 1'b0, 1'b1, c[1], c[0], 1'b0, 1'b0, 8'hFF, "R7 enable combo");
    step(8'h00, 8'h00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R6 a_out off");
    step(8'h4B, 8'h00, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R8 store disabled");
    step(8'h00, 8'h00, 2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8 readback");
    step(8'h00, 8'h5A, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, "R10 external pull");
    for (int k = 0; k < 400; k++) begin
      logic [7:0] ra, re, ra2;
      logic [1:0] om, im;
      ra = 8'($urandom); ra2 = 8'($urandom);
      re = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      om = 2'($urandom); im = 2'($urandom);
      step(ra, re, om, im, 1'($urandom), 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), ra2, "R1/R2/R3/R4/R5 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule